// File: doc/BRIEF.md
# ADC Conversion Start Selector

This block produces the single-cycle start request that launches an ADC conversion sequence. There are two ways to request a start. The first is a software strobe from the control interface. The second is a hardware trigger taken from one of several sources: a set of timer waveform outputs that are already in the clock domain, and one external trigger pin. The external pin is asynchronous, so it passes through a synchroniser first.

A 3-bit select field picks the hardware source, and an enable bit arms it. Hardware starts are taken only on rising edges of the chosen source, never on its level. The software strobe is never masked, so either path can start a sequence at any time. The output is registered and is a clean one-cycle pulse for the downstream sequencer.

Top module: `adc_start_select`

## Requirements
- R1: When `swStart` is high at a rising clock edge, `startPulse` is high for the following cycle, whatever the values of `trigEn` and `trigSel`.
- R2: Select codes 0, 1 and 2 choose `timerWave[0]`, `timerWave[1]` and `timerWave[2]`. Code 3 chooses `extTrig`.
- R3: While `trigEn` is low, no hardware source produces a start.
- R4: Select codes 4 to 7 are reserved and never produce a hardware start.
- R5: A selected source that rises and then stays high gives exactly one start, not one per cycle at high level.
- R6: A rising edge on `extTrig` that is first sampled at clock edge k shows on `startPulse` in the cycle after edge k+2. This is two synchroniser cycles plus the output register.
- R7: Edge history is kept for every source on every cycle. Setting `trigEn` while the selected source is already high produces no start.
- R8: Changing `trigSel` to a source that is already high produces no start.
- R9: A software strobe and a hardware edge in the same cycle give a single one-cycle pulse.
- R10: `startPulse` is low while `rstN` is low and in the first cycle after reset is released.
- R11: A rising edge on a selected timer output that is first sampled at clock edge k shows on `startPulse` in the cycle after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swStart | input | 1 | Software start strobe |
| trigSel | input | 3 | Hardware trigger source select |
| trigEn | input | 1 | Hardware trigger enable |
| timerWave | input | NUM_TIMERS | Timer waveform outputs, same clock domain |
| extTrig | input | 1 | External trigger pin, asynchronous |
| startPulse | output | 1 | One-cycle conversion start request |

## Verification
The hardest conditions to reach are the ones where a source is already high at the moment the hardware path becomes relevant. One case is the enable bit being set while the source is high. The other is the select field moving onto a source that is already high. Neither case is a plain edge event. The bench raises a source while it is disabled or unselected, lets the synchroniser and history settle, and only then changes `trigEn` or `trigSel`, watching for a pulse that must not appear. An exhaustive sweep over every select code, both enable values and every source provides the positive and negative edge cases, and it checks the latency for each source.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  localparam int SEL_W = 3;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic             swReq;   // software start this cycle
    logic             hwArm;   // hardware path enabled with a valid code
    logic [SEL_W-1:0] srcIdx;  // index into the source vector
  } trigCtl_t;

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic             swStart,
  input  logic [SEL_W-1:0] trigSel,
  input  logic             trigEn,
  output trigCtl_t         ctl
);

  logic codeValid;

  always_comb begin
    codeValid  = (int'(trigSel) < NUM_SRC);
    ctl.swReq  = swStart;
    ctl.hwArm  = trigEn && codeValid;
    ctl.srcIdx = trigSel;
  end

endmodule

// File: rtl/adc_trig_dp.sv
module adc_trig_dp
  import adc_trig_pkg::*;
#(
  parameter int NUM_TIMERS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_TIMERS-1:0] timerWave,
  input  logic                  extTrig,
  input  trigCtl_t              ctl,
  output logic                  startPulse
);

  localparam int NUM_SRC = NUM_TIMERS + 1;

  logic               extSync;
  logic [NUM_SRC-1:0] srcLvl;
  logic [NUM_SRC-1:0] srcHist;
  logic [NUM_SRC-1:0] srcRise;
  logic               hwEdge;
  logic               startQ;

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (extTrig),
    .syncOut (extSync)
  );

  assign srcLvl = {extSync, timerWave};

  // One history bit per source, refreshed every cycle regardless of selection
  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_hist
      always_ff @(posedge clk) begin
        if (!rstN) srcHist[g] <= 1'b0;
        else       srcHist[g] <= srcLvl[g];
      end
      assign srcRise[g] = srcLvl[g] & ~srcHist[g];
    end
  endgenerate

  always_comb begin
    hwEdge = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (int'(ctl.srcIdx) == i) hwEdge = srcRise[i];
    end
    hwEdge = hwEdge & ctl.hwArm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) startQ <= 1'b0;
    else       startQ <= ctl.swReq | hwEdge;
  end

  assign startPulse = startQ;

endmodule

// File: rtl/adc_start_select.sv
module adc_start_select
  import adc_trig_pkg::*;
#(
  parameter int NUM_TIMERS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  swStart,
  input  logic [2:0]            trigSel,
  input  logic                  trigEn,
  input  logic [NUM_TIMERS-1:0] timerWave,
  input  logic                  extTrig,
  output logic                  startPulse
);

  localparam int NUM_SRC = NUM_TIMERS + 1;

  trigCtl_t ctl;

  adc_trig_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .swStart (swStart),
    .trigSel (trigSel),
    .trigEn  (trigEn),
    .ctl     (ctl)
  );

  adc_trig_dp #(
    .NUM_TIMERS  (NUM_TIMERS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .timerWave  (timerWave),
    .extTrig    (extTrig),
    .ctl        (ctl),
    .startPulse (startPulse)
  );

endmodule

// File: rtl/adc_start_select_chk.sv
module adc_start_select_chk #(
  parameter int NUM_TIMERS = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  swStart,
  input logic [2:0]            trigSel,
  input logic                  trigEn,
  input logic [NUM_TIMERS-1:0] timerWave,
  input logic                  extTrig,
  input logic                  startPulse
);

  localparam int NUM_SRC = NUM_TIMERS + 1;

  logic selTimerLvl;
  logic selTimer;

  always_comb begin
    selTimerLvl = 1'b0;
    selTimer    = 1'b0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (int'(trigSel) == i) begin
        selTimerLvl = timerWave[i];
        selTimer    = 1'b1;
      end
    end
  end

  AST_SW_START: assert property (@(posedge clk) disable iff (!rstN)
    swStart |=> startPulse);                                          // R1

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!swStart && !trigEn) |=> !startPulse);                           // R3

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!swStart && int'(trigSel) >= NUM_SRC) |=> !startPulse);          // R4

  AST_TIMER_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (trigEn && selTimer && $stable(trigSel) && selTimerLvl && !$past(selTimerLvl))
      |=> startPulse);                                                // R11

  AST_LEVEL_NO_REPEAT: assert property (@(posedge clk) disable iff (!rstN)
    (!swStart && selTimer && $stable(trigSel) && selTimerLvl && $past(selTimerLvl))
      |=> !startPulse);                                               // R5

  AST_ENABLE_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    (!swStart && $rose(trigEn) && selTimer && $stable(trigSel) &&
     selTimerLvl && $past(selTimerLvl)) |=> !startPulse);             // R7

endmodule

bind adc_start_select adc_start_select_chk #(.NUM_TIMERS(NUM_TIMERS)) u_chk (.*);

// File: tb/adc_start_select_tb.sv
module adc_start_select_tb;

  localparam int NT = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          swStart = 1'b0;
  logic [2:0]    trigSel = 3'd0;
  logic          trigEn = 1'b0;
  logic [NT-1:0] timerWave = '0;
  logic          extTrig = 1'b0;
  logic          startPulse;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 0;

  always #4 clk = ~clk;

  adc_start_select #(.NUM_TIMERS(NT)) u_dut (
    .clk(clk), .rstN(rstN), .swStart(swStart), .trigSel(trigSel),
    .trigEn(trigEn), .timerWave(timerWave), .extTrig(extTrig),
    .startPulse(startPulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setSrc(input int src, input logic v);
    if (src < NT) timerWave[src] = v;
    else          extTrig = v;
  endtask

  task automatic quiet(input int n);
    @(negedge clk);
    timerWave = '0; extTrig = 1'b0; swStart = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Observe over a window; returns the pulse count and the first sample index
  task automatic observe(input int n, output int cnt, output int first);
    cnt = 0; first = -1;
    for (int j = 0; j < n; j++) begin
      @(posedge clk); #1;
      if (startPulse) begin
        if (first < 0) first = j;
        cnt++;
      end
    end
  endtask

  task automatic runEdge(input int sel, input int en, input int src);
    int cnt, first, expCnt, expFirst;
    quiet(1);
    trigSel = 3'(sel); trigEn = en[0];
    repeat (5) @(negedge clk);
    setSrc(src, 1'b1);
    observe(8, cnt, first);
    expCnt   = (en != 0 && sel < NT + 1 && sel == src) ? 1 : 0;
    expFirst = (src == NT) ? 2 : 0;
    if (en == 0)
      check(cnt == expCnt, $sformatf("R3 sel=%0d src=%0d", sel, src), cnt, expCnt);
    else if (sel >= NT + 1)
      check(cnt == expCnt, $sformatf("R4 sel=%0d src=%0d", sel, src), cnt, expCnt);
    else
      check(cnt == expCnt, $sformatf("R2 R5 sel=%0d src=%0d", sel, src), cnt, expCnt);
    if (expCnt == 1) begin
      if (src == NT) check(first == expFirst, "R6 ext latency", first, expFirst);
      else check(first == expFirst, $sformatf("R11 timer%0d latency", src), first, expFirst);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!doneFlag) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int cnt, first;
    // R10: reset state
    repeat (3) @(negedge clk);
    check(startPulse == 1'b0, "R10 in reset", startPulse, 0);
    swStart = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    swStart = 1'b0;
    @(posedge clk); #1;
    check(startPulse == 1'b0, "R10 after release", startPulse, 0);

    // R1: software start under every select code and enable value
    for (int s = 0; s < 8; s++) begin
      for (int e = 0; e < 2; e++) begin
        quiet(2);
        trigSel = 3'(s); trigEn = e[0];
        swStart = 1'b1;
        @(posedge clk); #1;
        check(startPulse == 1'b1, $sformatf("R1 sel=%0d en=%0d", s, e), startPulse, 1);
        swStart = 1'b0;
        @(posedge clk); #1;
        check(startPulse == 1'b0, "R1 single cycle", startPulse, 0);
      end
    end

    // Exhaustive sweep: select code x enable x source (R2 R3 R4 R5 R6 R11)
    for (int s = 0; s < 8; s++)
      for (int e = 0; e < 2; e++)
        for (int src = 0; src <= NT; src++)
          runEdge(s, e, src);

    // R7: enabling while selected source already high
    for (int src = 0; src <= NT; src++) begin
      quiet(2);
      trigSel = 3'(src); trigEn = 1'b0;
      setSrc(src, 1'b1);
      repeat (5) @(negedge clk);
      trigEn = 1'b1;
      observe(6, cnt, first);
      check(cnt == 0, $sformatf("R7 enable while high src=%0d", src), cnt, 0);
    end

    // R8: switching select onto a source already high
    for (int src = 0; src <= NT; src++) begin
      quiet(2);
      trigEn = 1'b1;
      trigSel = 3'((src + 1) % (NT + 1));
      setSrc(src, 1'b1);
      repeat (5) @(negedge clk);
      trigSel = 3'(src);
      observe(6, cnt, first);
      check(cnt == 0, $sformatf("R8 switch to high src=%0d", src), cnt, 0);
    end

    // R9: software and timer edge together
    for (int src = 0; src < NT; src++) begin
      quiet(2);
      trigEn = 1'b1; trigSel = 3'(src);
      repeat (2) @(negedge clk);
      setSrc(src, 1'b1);
      swStart = 1'b1;
      @(posedge clk); #1;
      swStart = 1'b0;
      check(startPulse == 1'b1, "R9 coincident pulse", startPulse, 1);
      observe(5, cnt, first);
      check(cnt == 0, "R9 no second pulse", cnt, 0);
    end

    doneFlag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule